// File: doc/BRIEF.md
# Delayed-Synapse Accumulating Neuron

This block is one digital integrate-and-fire neuron with programmable per-synapse delays. Input spikes arrive as address events that name one of the neuron's synapses. For each accepted event the block fetches that synapse's signed weight and its delay from a local table. It then adds the weight into one slot of a small circular buffer. The slot chosen is the delay, counted from the slot that will be consumed next.

A plain `tick` pulse marks one step of model time. On each tick the block does four things. It applies a shift-based exponential leak to the membrane accumulator. It adds the pending slot, clears that slot and advances the ring. It then compares the result against the threshold raised by a decaying refractory term. A crossing produces a one-cycle output spike, resets the accumulator and boosts the refractory term.

Synapse weights and delays are loaded through a simple write port. The threshold, the leak shift and the refractory boost are static control inputs.

The event input is a valid/ready stream. An event counts only in a cycle where `evt_valid` and `evt_ready` are both high. `evt_ready` falls during every tick cycle, so the source must hold the event and its address until a later cycle. The spike output is a plain one-cycle pulse and has no back-pressure.

Top module: `spiking_neuron_core`

## Requirements
- R1: After reset the membrane value is 0, `spike_o` is 0, `evt_ready` is 1, every ring slot holds 0, the ring points at slot 0, the refractory term is 0 and every synapse has weight 0 and delay 0.
- R2: When `cfg_we` is high, the table stores `cfg_weight` (8-bit two's complement) and `cfg_delay` (4-bit unsigned) for synapse `cfg_addr` at the clock edge. Later events on that synapse use the stored pair.
- R3: `evt_ready` is low in exactly the cycles where `tick` is high. An event offered while `evt_ready` is low is dropped and has no effect on any later membrane value.
- R4: An event accepted with delay d adds its weight to the membrane at the (d+1)-th tick after acceptance, and at no earlier tick.
- R5: All weights that land in the same ring slot are summed, and the sum saturates to the signed range of the slot width (-2048..2047 at default parameters).
- R6: On a tick the membrane becomes sat16(m - (m >>> k) + s). Here m is the old membrane, k is `leak_shift` (arithmetic shift), s is the due slot and sat16 clamps to -32768..32767. The due slot is then cleared and the ring moves to the next slot.
- R7: In a cycle with no tick the membrane and the refractory term keep their values.
- R8: On a tick where the new membrane value is at least `threshold` (signed) plus the refractory term, `spike_o` is 1 in the cycle after the tick and the membrane becomes 0. `spike_o` is 0 in every other cycle.
- R9: On each tick the refractory term is shifted right by one bit. On a tick that fires, `refr_boost` is then added to it, saturating at 65535.
- R10: A membrane sum that leaves the 16-bit signed range is clamped to 32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An input spike event is offered |
| evt_ready | output | 1 | The event can be accepted this cycle (low during a tick) |
| evt_syn | input | 7 | Synapse index of the offered event |
| tick | input | 1 | One model time step: leak, integrate, fire |
| cfg_we | input | 1 | Write strobe for the synapse table |
| cfg_addr | input | 7 | Synapse index to write |
| cfg_weight | input | 8 | Signed weight to store |
| cfg_delay | input | 4 | Delay in ticks to store |
| threshold | input | 16 | Signed base firing threshold |
| leak_shift | input | 4 | Leak shift k |
| refr_boost | input | 16 | Unsigned amount added to the refractory term on a spike |
| spike_o | output | 1 | One-cycle output spike |
| membrane_o | output | 16 | Signed membrane accumulator |

## Verification
The bench builds the block with its default parameters: 128 synapses, 8-bit weights, 4-bit delays (16 slots), a 12-bit slot sum and a 16-bit membrane. At these widths the slot clamp needs only about seventeen maximum-weight events in one slot. Pushing the membrane into its negative clamp takes about twenty ticks. So both saturation limits are reached with directed sequences, and the random phase covers every delay value and many ring wrap-arounds.

// File: rtl/neuron_pkg.sv
package neuron_pkg;
  // Default geometry of one neuron
  localparam int DEF_N_SYN  = 128;
  localparam int DEF_W_W    = 8;
  localparam int DEF_D_W    = 4;
  localparam int DEF_SLOT_W = 12;
  localparam int DEF_ACC_W  = 16;

  // Outcome of one time step in the soma
  typedef enum logic [1:0] {
    STEP_IDLE  = 2'd0,
    STEP_QUIET = 2'd1,
    STEP_FIRE  = 2'd2
  } step_kind_e;
endpackage

// File: rtl/neuron_syn_table.sv
module neuron_syn_table #(
  parameter int N_SYN = 128,
  parameter int W_W   = 8,
  parameter int D_W   = 4,
  localparam int SYN_W = $clog2(N_SYN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SYN_W-1:0]      wr_addr,
  input  logic signed [W_W-1:0] wr_weight,
  input  logic [D_W-1:0]        wr_delay,
  input  logic [SYN_W-1:0]      rd_addr,
  output logic signed [W_W-1:0] rd_weight,
  output logic [D_W-1:0]        rd_delay
);
  logic signed [W_W-1:0] wt_mem [N_SYN];
  logic [D_W-1:0]        dl_mem [N_SYN];

  for (genvar g = 0; g < N_SYN; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wt_mem[g] <= '0;
        dl_mem[g] <= '0;
      end else if (wr_en && (wr_addr == SYN_W'(g))) begin
        wt_mem[g] <= wr_weight;
        dl_mem[g] <= wr_delay;
      end
    end
  end

  assign rd_weight = wt_mem[rd_addr];
  assign rd_delay  = dl_mem[rd_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wt_mem[$past(wr_addr)] == $past(wr_weight)) &&
              (dl_mem[$past(wr_addr)] == $past(wr_delay))); // R2
endmodule

// File: rtl/neuron_delay_ring.sv
module neuron_delay_ring #(
  parameter int W_W    = 8,
  parameter int D_W    = 4,
  parameter int SLOT_W = 12,
  localparam int N_SLOT = 1 << D_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [D_W-1:0]           wr_off,
  input  logic signed [W_W-1:0]    wr_val,
  input  logic                     step,
  output logic signed [SLOT_W-1:0] due_val
);
  localparam logic [SLOT_W:0] S_MAX = {2'b00, {(SLOT_W-1){1'b1}}};
  localparam logic [SLOT_W:0] S_MIN = {2'b11, {(SLOT_W-1){1'b0}}};

  logic signed [SLOT_W-1:0] slots [N_SLOT];
  logic [D_W-1:0]           ptr_q;
  logic [D_W-1:0]           wr_idx;

  // Target slot is relative to the slot consumed at the next step
  assign wr_idx  = ptr_q + wr_off;
  assign due_val = slots[ptr_q];

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (step) ptr_q <= ptr_q + 1'b1;
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic [SLOT_W:0]       sum;
    logic [SLOT_W-1:0]     clamped;
    always_comb begin
      sum = {slots[g][SLOT_W-1], slots[g]} +
            {{(SLOT_W+1-W_W){wr_val[W_W-1]}}, wr_val};
      if (sum[SLOT_W] != sum[SLOT_W-1])
        clamped = sum[SLOT_W] ? S_MIN[SLOT_W-1:0] : S_MAX[SLOT_W-1:0];
      else
        clamped = sum[SLOT_W-1:0];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)
        slots[g] <= '0;
      else if (step && (ptr_q == D_W'(g)))
        slots[g] <= '0;
      else if (wr_en && (wr_idx == D_W'(g)))
        slots[g] <= $signed(clamped);
    end
  end

  AST_SLOT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> slots[$past(ptr_q)] == '0); // R6
  AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ptr_q == D_W'($past(ptr_q) + 1'b1)); // R6
  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr_q)); // R4
endmodule

// File: rtl/neuron_soma.sv
module neuron_soma
  import neuron_pkg::*;
#(
  parameter int SLOT_W = 12,
  parameter int ACC_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step,
  input  logic signed [SLOT_W-1:0] due_val,
  input  logic signed [ACC_W-1:0]  threshold,
  input  logic [3:0]               leak_shift,
  input  logic [ACC_W-1:0]         refr_boost,
  output logic signed [ACC_W-1:0]  membrane,
  output logic                     spike
);
  localparam logic [ACC_W-1:0] A_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] A_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, leaked, acc_new;
  logic [ACC_W-1:0]        refr_q, refr_half, refr_next;
  logic [ACC_W:0]          sum, rsum;
  logic signed [ACC_W+1:0] eff_thr, cand;
  logic                    fire;
  step_kind_e              kind;

  always_comb begin
    leaked  = acc_q - (acc_q >>> leak_shift);
    sum     = {leaked[ACC_W-1], leaked} +
              {{(ACC_W+1-SLOT_W){due_val[SLOT_W-1]}}, due_val};
    if (sum[ACC_W] != sum[ACC_W-1])
      acc_new = sum[ACC_W] ? $signed(A_MIN) : $signed(A_MAX);
    else
      acc_new = $signed(sum[ACC_W-1:0]);
    eff_thr = $signed({{2{threshold[ACC_W-1]}}, threshold}) +
              $signed({2'b00, refr_q});
    cand    = $signed({{2{acc_new[ACC_W-1]}}, acc_new});
    fire    = cand >= eff_thr;
    refr_half = refr_q >> 1;
    rsum      = {1'b0, refr_half} + {1'b0, refr_boost};
    if (fire) refr_next = rsum[ACC_W] ? '1 : rsum[ACC_W-1:0];
    else      refr_next = refr_half;
    if (!step)     kind = STEP_IDLE;
    else if (fire) kind = STEP_FIRE;
    else           kind = STEP_QUIET;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      refr_q <= '0;
      spike  <= 1'b0;
    end else begin
      spike <= (kind == STEP_FIRE);
      case (kind)
        STEP_FIRE: begin
          acc_q  <= '0;
          refr_q <= refr_next;
        end
        STEP_QUIET: begin
          acc_q  <= acc_new;
          refr_q <= refr_next;
        end
        default: ;
      endcase
    end
  end

  assign membrane = acc_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(acc_q) && $stable(refr_q)); // R7
  AST_SPIKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> acc_q == '0); // R8
  AST_SPIKE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> $past(step)); // R8
  AST_REFR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (spike && refr_boost != '0 && $stable(refr_boost)) |-> refr_q != '0); // R9
endmodule

// File: rtl/spiking_neuron_core.sv
module spiking_neuron_core
  import neuron_pkg::*;
#(
  parameter int N_SYN  = DEF_N_SYN,
  parameter int W_W    = DEF_W_W,
  parameter int D_W    = DEF_D_W,
  parameter int SLOT_W = DEF_SLOT_W,
  parameter int ACC_W  = DEF_ACC_W,
  localparam int SYN_W = $clog2(N_SYN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [SYN_W-1:0] evt_syn,
  input  logic             tick,
  input  logic             cfg_we,
  input  logic [SYN_W-1:0] cfg_addr,
  input  logic [W_W-1:0]   cfg_weight,
  input  logic [D_W-1:0]   cfg_delay,
  input  logic [ACC_W-1:0] threshold,
  input  logic [3:0]       leak_shift,
  input  logic [ACC_W-1:0] refr_boost,
  output logic             spike_o,
  output logic [ACC_W-1:0] membrane_o
);
  logic signed [W_W-1:0]    lk_weight;
  logic [D_W-1:0]           lk_delay;
  logic signed [SLOT_W-1:0] due_val;
  logic signed [ACC_W-1:0]  membrane;
  logic                     accept;

  // The ring is busy consuming a slot during a tick
  assign evt_ready = ~tick;
  assign accept    = evt_valid & evt_ready;

  neuron_syn_table #(.N_SYN(N_SYN), .W_W(W_W), .D_W(D_W)) i_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_weight($signed(cfg_weight)), .wr_delay(cfg_delay),
    .rd_addr(evt_syn), .rd_weight(lk_weight), .rd_delay(lk_delay)
  );

  neuron_delay_ring #(.W_W(W_W), .D_W(D_W), .SLOT_W(SLOT_W)) i_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept), .wr_off(lk_delay), .wr_val(lk_weight),
    .step(tick), .due_val(due_val)
  );

  neuron_soma #(.SLOT_W(SLOT_W), .ACC_W(ACC_W)) i_soma (
    .clk(clk), .rst_n(rst_n),
    .step(tick), .due_val(due_val),
    .threshold($signed(threshold)), .leak_shift(leak_shift),
    .refr_boost(refr_boost),
    .membrane(membrane), .spike(spike_o)
  );

  assign membrane_o = membrane;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !evt_ready); // R3
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> evt_ready); // R3
endmodule

// File: tb/test_spiking_neuron_core.sv
`timescale 1ns/1ps
module test_spiking_neuron_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [6:0]  evt_syn = '0;
  logic        tick = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [7:0]  cfg_weight = '0;
  logic [3:0]  cfg_delay = '0;
  logic [15:0] threshold = 16'd30000;
  logic [3:0]  leak_shift = 4'd15;
  logic [15:0] refr_boost = '0;
  logic        spike_o;
  logic [15:0] membrane_o;

  always #10 clk = ~clk;

  spiking_neuron_core i_spiking_neuron_core (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_syn(evt_syn), .tick(tick), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_weight(cfg_weight), .cfg_delay(cfg_delay), .threshold(threshold),
    .leak_shift(leak_shift), .refr_boost(refr_boost),
    .spike_o(spike_o), .membrane_o(membrane_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int m_w [128];
  int m_d [128];
  int m_slot [16];
  int m_ptr, m_acc, m_refr;
  bit m_spike;

  function automatic int clamp(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (m_w[i]) begin m_w[i] = 0; m_d[i] = 0; end
    foreach (m_slot[i]) m_slot[i] = 0;
    m_ptr = 0; m_acc = 0; m_refr = 0; m_spike = 0;
  endtask

  task automatic model_tick();
    int leaked, nv, eff, half;
    bit fire;
    leaked = m_acc - (m_acc >>> int'(leak_shift));
    nv = clamp(leaked + m_slot[m_ptr], -32768, 32767);
    eff = int'($signed(threshold)) + m_refr;
    fire = (nv >= eff);
    half = m_refr >> 1;
    m_refr = fire ? clamp(half + int'(refr_boost), 0, 65535) : half;
    m_acc = fire ? 0 : nv;
    m_spike = fire;
    m_slot[m_ptr] = 0;
    m_ptr = (m_ptr + 1) % 16;
  endtask

  task automatic do_cfg(int a, int w, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(a); cfg_weight = 8'(w); cfg_delay = 4'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    m_w[a] = w; m_d[a] = d;
  endtask

  task automatic do_event(int s);
    int idx;
    @(negedge clk);
    evt_valid = 1'b1; evt_syn = 7'(s);
    #1 chk(evt_ready === 1'b1, "R3 ready without tick", int'(evt_ready), 1);
    @(negedge clk);
    evt_valid = 1'b0;
    idx = (m_ptr + m_d[s]) % 16;
    m_slot[idx] = clamp(m_slot[idx] + m_w[s], -2048, 2047);
  endtask

  task automatic do_tick(string req, bit with_evt = 0, int s = 0);
    @(negedge clk);
    tick = 1'b1;
    if (with_evt) begin evt_valid = 1'b1; evt_syn = 7'(s); end
    #1 chk(evt_ready === 1'b0, "R3 ready low on tick", int'(evt_ready), 0);
    @(negedge clk);
    tick = 1'b0; evt_valid = 1'b0;
    model_tick();
    chk(int'($signed(membrane_o)) == m_acc, req, int'($signed(membrane_o)), m_acc);
    chk(spike_o === m_spike, {req, " spike"}, int'(spike_o), int'(m_spike));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk(membrane_o == 16'd0, "R1 membrane", int'(membrane_o), 0);
    chk(spike_o == 1'b0, "R1 spike", int'(spike_o), 0);
    chk(evt_ready == 1'b1, "R1 ready", int'(evt_ready), 1);
    do_event(3);  // weight 0 after reset
    do_tick("R1 empty table");

    // R4 delay 2 arrives at third tick; R2 table write used
    do_cfg(5, 100, 2);
    do_event(5);
    do_tick("R4 not yet 1");
    chk(m_acc == 0, "R4 early", m_acc, 0);
    do_tick("R4 not yet 2");
    do_tick("R4 arrival");
    chk(int'($signed(membrane_o)) == 100, "R2 R4 weight landed", int'($signed(membrane_o)), 100);

    // R5 slot saturation
    leak_shift = 4'd0;
    do_tick("R6 k0 clears");
    chk(membrane_o == 16'd0, "R6 k0 value", int'(membrane_o), 0);
    leak_shift = 4'd15;
    do_cfg(7, 127, 0);
    repeat (20) do_event(7);
    do_tick("R5 slot clamp");
    chk(int'($signed(membrane_o)) == 2047, "R5 clamp value", int'($signed(membrane_o)), 2047);

    // R10 negative clamp of membrane
    do_cfg(8, -128, 0);
    for (int r = 0; r < 20; r++) begin
      repeat (17) do_event(8);
      do_tick("R10 descent");
    end
    chk(int'($signed(membrane_o)) == -32768, "R10 floor", int'($signed(membrane_o)), -32768);

    // R7 idle cycles hold
    repeat (5) @(negedge clk);
    chk(int'($signed(membrane_o)) == m_acc, "R7 hold", int'($signed(membrane_o)), m_acc);
    leak_shift = 4'd0;
    do_tick("R6 reset via k0");

    // R8 firing and R9 refractory
    leak_shift = 4'd15; threshold = 16'd500; refr_boost = 16'd1000;
    do_cfg(9, 120, 0);
    repeat (5) do_event(9);
    do_tick("R8 fire");
    chk(spike_o == 1'b1, "R8 spike seen", int'(spike_o), 1);
    @(negedge clk);
    chk(spike_o == 1'b0, "R8 one cycle", int'(spike_o), 0);
    repeat (5) do_event(9);
    do_tick("R9 refractory blocks");
    chk(spike_o == 1'b0, "R9 no spike", int'(spike_o), 0);

    // R3 event offered during tick is dropped
    do_tick("R3 dropped event", 1, 9);
    repeat (16) do_tick("R3 drop effect");

    // random phase
    threshold = 16'd1500; refr_boost = 16'd800;
    for (int a = 0; a < 128; a++) begin
      w = int'($urandom_range(0, 187)) - 60;
      do_cfg(a, w, int'($urandom_range(0, 15)));
    end
    for (int n = 0; n < 700; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) begin
        w = int'($urandom_range(0, 187)) - 60;
        do_cfg(int'($urandom_range(0, 127)), w, int'($urandom_range(0, 15)));
      end else if (r <= 6) begin
        do_event(int'($urandom_range(0, 127)));
      end else begin
        leak_shift = 4'($urandom_range(1, 8));
        do_tick("R6 R8 R9 random", r == 9, int'($urandom_range(0, 127)));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule